// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Output Quantizer

This block is the arithmetic core of a DSP data path. Each accepted command multiplies two signed 16-bit operands and then clears, adds to, subtracts from or loads a wide accumulator. Before the multiply, each operand gets one extra sign bit, so the signed multiplier is 17 by 17. The accumulator is 40 bits wide. That holds the full double-width product plus eight guard bits, so long sums of products do not overflow on the way. When fractional mode is set, the product is shifted left by one place. This removes the duplicated sign bit that a fractional-by-fractional product carries.

The accumulator is always visible at full width. A quantizer also narrows it to a 16-bit word. It keeps bits 31 to 16 of the accumulator, which is the upper product word. It handles the 16 dropped bits by rounding, by value truncation or by magnitude truncation. A result that does not fit in 16 bits is replaced according to the selected overflow behaviour: saturate, force zero or wrap. Quantization and overflow selects are plain control pins. They act on the output word combinationally, so the same accumulator can be read out in different ways.

Commands arrive on a valid/ready stream, and results leave on a valid/ready stream. A command transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds nothing, or holds a result that is being taken in the same cycle. A result stays presented, unchanged, until `out_ready` takes it. Because of this, a stalled consumer stops new commands from changing the accumulator.

Top module: `fxp_mac_unit`

## Requirements
- R1: After a synchronous active-high reset, `acc_out` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: Operands are signed two's complement. The product is the exact signed product a·b, sign-extended to 40 bits. Opcode 3 (load) sets the accumulator to the product.
- R3: When `frac_en` is 1 at transfer, the product used is 2·a·b, with a zero filled in at the LSB.
- R4: Opcode 0 clears the accumulator, opcode 1 adds the product and opcode 2 subtracts it. The accumulator wraps modulo 2^40.
- R5: A command transfers only when `in_valid` and `in_ready` are both high. `in_ready` equals NOT `out_valid` OR `out_ready`. After a transfer, `out_valid` is 1 on the next cycle and stays 1 until `out_ready` is seen. While a result waits, the accumulator does not change.
- R6: With `qsel`=0, the quantized value is floor(acc/2^16 + 1/2). This rounds half up, so −0.25 gives 0, −0.5 gives 0 and −0.75 gives −1.
- R7: With `qsel`=1 or 3, the quantized value is floor(acc/2^16). This is value truncation, so −0.25 gives −1.
- R8: With `qsel`=2, the quantized value is acc/2^16 rounded toward zero. This is magnitude truncation, so −0.25 and −0.75 both give 0.
- R9: A quantized value outside [−32768, 32767] is an overflow. With `osel`=0 (saturate), a positive overflow outputs 32767 and a negative overflow outputs −32768.
- R10: With `osel`=0 and `sat_sym`=1, every value at or below −32768 outputs −32767 (0x8001), whether or not it overflowed.
- R11: With `osel`=1, an overflow outputs 0.
- R12: With `osel`=2 or 3, the output is the low 16 bits of the quantized value (wraparound modulo 2^16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be accepted this cycle |
| in_op | input | 2 | 0 clear, 1 add product, 2 subtract product, 3 load product |
| in_a | input | 16 | Signed operand A |
| in_b | input | 16 | Signed operand B |
| frac_en | input | 1 | Fractional mode: double the product |
| qsel | input | 2 | Quantization: 0 round, 1 or 3 value truncate, 2 magnitude truncate |
| osel | input | 2 | Overflow: 0 saturate, 1 zero, 2 or 3 wrap |
| sat_sym | input | 1 | Symmetric saturation range |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | 40 | Full accumulator |
| q_out | output | 16 | Quantized, overflow-handled word |

## Verification
The bench builds the block with its defaults: 16-bit operands, 8 guard bits and 16 dropped bits. With these values, the overflow edges at ±2^31 in the accumulator are reached with only one to three full-scale fractional products. The exact −32768 case for symmetric saturation is reached by one load followed by two subtractions. The same defaults let a run of a few hundred full-scale products go past the guard range, so the 2^40 wrap of the accumulator falls inside a short run. The boundary cases −0.25, −0.5 and −0.75 sit directly in the 16 dropped bits.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
  typedef enum logic [1:0] {
    OP_CLR  = 2'd0,
    OP_MAC  = 2'd1,
    OP_MSU  = 2'd2,
    OP_LOAD = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    QZ_ROUND  = 2'd0,
    QZ_FLOOR  = 2'd1,
    QZ_TOZERO = 2'd2,
    QZ_FLOOR2 = 2'd3
  } qz_mode_e;

  typedef enum logic [1:0] {
    OV_SAT   = 2'd0,
    OV_ZERO  = 2'd1,
    OV_WRAP  = 2'd2,
    OV_WRAP2 = 2'd3
  } ov_mode_e;
endpackage

// File: rtl/fxp_mac_mult.sv
module fxp_mac_mult #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [IN_W-1:0]         a,
  input  logic [IN_W-1:0]         b,
  input  logic                    frac,
  output logic signed [ACC_W-1:0] prod
);
  localparam int MW = IN_W + 1;
  localparam int PW = 2 * MW;

  logic signed [MW-1:0]    ax, bx;
  logic signed [PW-1:0]    p;
  logic signed [ACC_W-1:0] pext;

  assign ax = {a[IN_W-1], a};
  assign bx = {b[IN_W-1], b};
  assign p  = PW'(ax) * PW'(bx);

  generate
    if (ACC_W > PW) begin : g_ext
      assign pext = {{(ACC_W-PW){p[PW-1]}}, p};
    end else begin : g_trim
      assign pext = p[ACC_W-1:0];
    end
  endgenerate

  // Fractional mode: one left shift drops the duplicated sign bit.
  assign prod = frac ? {pext[ACC_W-2:0], 1'b0} : pext;
endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc
  import fxp_mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              op,
  input  logic signed [ACC_W-1:0] prod,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] acc
);
  logic fire;
  logic signed [ACC_W-1:0] acc_nx;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    unique case (mac_op_e'(op))
      OP_CLR:  acc_nx = '0;
      OP_MAC:  acc_nx = acc + prod;
      OP_MSU:  acc_nx = acc - prod;
      default: acc_nx = prod;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (fire) acc <= acc_nx;
      if (fire) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc)));
  a_r5_valid_after_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_CLR) |=> (acc == '0));
  a_r2_load_prod: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_LOAD) |=> (acc == $past(prod)));
endmodule

// File: rtl/fxp_mac_quant.sv
module fxp_mac_quant
  import fxp_mac_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int DROP  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [1:0]              qsel,
  input  logic [1:0]              osel,
  input  logic                    sym,
  output logic [OUT_W-1:0]        y
);
  localparam int KW = ACC_W - DROP + 1;
  localparam logic [ACC_W:0] HALF = {{(ACC_W-DROP+1){1'b0}}, 1'b1, {(DROP-1){1'b0}}};
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEGV = {1'b1, {(OUT_W-1){1'b0}}};

  logic [ACC_W:0]      ax, rsum;
  logic [KW-1:0]       q_rnd, q_flr, q_tz, q;
  logic                bump, ovf, neg;
  logic [KW-OUT_W:0]   top;
  logic [OUT_W-1:0]    low, minv;

  assign ax    = {acc[ACC_W-1], acc};
  assign rsum  = ax + HALF;
  assign q_rnd = rsum[ACC_W:DROP];
  assign q_flr = ax[ACC_W:DROP];
  assign bump  = acc[ACC_W-1] && (|acc[DROP-1:0]);
  assign q_tz  = q_flr + {{(KW-1){1'b0}}, bump};

  always_comb begin
    unique case (qz_mode_e'(qsel))
      QZ_ROUND:  q = q_rnd;
      QZ_TOZERO: q = q_tz;
      default:   q = q_flr;
    endcase
  end

  assign top  = q[KW-1:OUT_W-1];
  assign ovf  = !((&top) || !(|top));
  assign neg  = q[KW-1];
  assign low  = q[OUT_W-1:0];
  assign minv = sym ? (NEGV | {{(OUT_W-1){1'b0}}, 1'b1}) : NEGV;

  always_comb begin
    unique case (ov_mode_e'(osel))
      OV_SAT: begin
        if (ovf)                     y = neg ? minv : MAXV;
        else if (sym && low == NEGV) y = minv;
        else                         y = low;
      end
      OV_ZERO: y = ovf ? '0 : low;
      default: y = low;
    endcase
  end

  a_r9_sat_pos: assert property (@(posedge clk) disable iff (rst)
    (osel == OV_SAT && !acc[ACC_W-1] && (|acc[ACC_W-2:DROP+OUT_W-1])) |-> (y == MAXV));
  a_r10_sym_no_min: assert property (@(posedge clk) disable iff (rst)
    (osel == OV_SAT && sym) |-> (y != NEGV));
  a_r11_zero_deep_neg: assert property (@(posedge clk) disable iff (rst)
    (osel == OV_ZERO && acc[ACC_W-1] && !(&acc[ACC_W-2:DROP+OUT_W])) |-> (y == '0));
  a_r12_wrap_floor: assert property (@(posedge clk) disable iff (rst)
    (osel == OV_WRAP && qsel == QZ_FLOOR) |-> (y == acc[DROP+OUT_W-1:DROP]));
endmodule

// File: rtl/fxp_mac_unit.sv
module fxp_mac_unit #(
  parameter int IN_W   = 16,
  parameter int GUARD_W = 8,
  parameter int ACC_W  = 2 * IN_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [IN_W-1:0]  in_a,
  input  logic [IN_W-1:0]  in_b,
  input  logic             frac_en,
  input  logic [1:0]       qsel,
  input  logic [1:0]       osel,
  input  logic             sat_sym,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] acc_out,
  output logic [IN_W-1:0]  q_out
);
  localparam int DROP = IN_W;

  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] acc;

  fxp_mac_mult #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mult (
    .a(in_a), .b(in_b), .frac(frac_en), .prod(prod)
  );

  fxp_mac_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(in_op), .prod(prod), .out_valid(out_valid), .out_ready(out_ready),
    .acc(acc)
  );

  fxp_mac_quant #(.ACC_W(ACC_W), .OUT_W(IN_W), .DROP(DROP)) u_quant (
    .clk(clk), .rst(rst), .acc(acc), .qsel(qsel), .osel(osel),
    .sym(sat_sym), .y(q_out)
  );

  assign acc_out = acc;
endmodule

// File: tb/fxp_mac_unit_bench.sv
module fxp_mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        frac_en = 1'b0;
  logic [1:0]  qsel = 2'd0, osel = 2'd0;
  logic        sat_sym = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] acc_out;
  logic [15:0] q_out;

  int tests = 0;
  int fails = 0;
  longint macc = 0;

  typedef struct { longint acc; int q; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  fxp_mac_unit u_fxp_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .frac_en(frac_en),
    .qsel(qsel), .osel(osel), .sat_sym(sat_sym), .out_valid(out_valid),
    .out_ready(out_ready), .acc_out(acc_out), .q_out(q_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int qmodel(input longint a, input int qs, input int os, input bit sy);
    longint v;
    int w;
    case (qs)
      0: v = (a + 32768) >>> 16;
      2: v = (a < 0) ? -((-a) >>> 16) : (a >>> 16);
      default: v = a >>> 16;
    endcase
    if (v > 32767 || v < -32768) begin
      case (os)
        0: return (v > 0) ? 32767 : (sy ? -32767 : -32768);
        1: return 0;
        default: begin
          w = int'(v & 65535);
          if (w >= 32768) w -= 65536;
          return w;
        end
      endcase
    end
    if (os == 0 && sy && v == -32768) return -32767;
    return int'(v);
  endfunction

  task automatic drive(input int op, input int a, input int b, input bit fr,
                       input int qs, input int os, input bit sy, input string tag);
    longint p;
    in_op = op[1:0]; in_a = a[15:0]; in_b = b[15:0]; frac_en = fr;
    qsel = qs[1:0]; osel = os[1:0]; sat_sym = sy; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    p = longint'(a) * longint'(b);
    if (fr) p = p * 2;
    case (op)
      0: macc = 0;
      1: macc = macc + p;
      2: macc = macc - p;
      default: macc = p;
    endcase
    macc = (macc <<< 24) >>> 24;
    sb.push_back('{macc, qmodel(macc, qs, os, sy), tag});
    @(posedge clk); #1 in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  // Monitor: compares each delivered result with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(longint'($signed(acc_out)) == e.acc, {e.tag, " acc"}, longint'($signed(acc_out)), e.acc);
        chk(int'($signed(q_out)) == e.q, {e.tag, " q"}, int'($signed(q_out)), e.q);
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(acc_out == '0, "R1 acc", longint'(acc_out), 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    @(posedge clk); #1;

    drive(3, 3, -5, 0, 1, 0, 0, "R2 int load");
    drive(3, -32768, 32767, 0, 0, 0, 0, "R2 extremes");
    drive(3, 16384, 16384, 1, 1, 0, 0, "R3 frac load");
    drive(1, 16384, 16384, 1, 1, 0, 0, "R4 mac");
    drive(2, 16384, 16384, 1, 1, 0, 0, "R4 msu");
    drive(0, 5, 5, 0, 1, 0, 0, "R4 clear");

    drive(3, -16384, 1, 0, 0, 0, 0, "R6 -0.25");
    drive(3, -32768, 1, 0, 0, 0, 0, "R6 -0.5");
    drive(3, -16384, 3, 0, 0, 0, 0, "R6 -0.75");
    drive(3, -16384, 1, 0, 1, 0, 0, "R7 -0.25");
    drive(3, -16384, 3, 0, 3, 0, 0, "R7 -0.75 alt");
    drive(3, -16384, 1, 0, 2, 0, 0, "R8 -0.25");
    drive(3, -16384, 3, 0, 2, 0, 0, "R8 -0.75");
    drive(3, 16384, 3, 0, 2, 0, 0, "R8 +0.75");

    drive(3, -32768, -32768, 1, 1, 0, 0, "R9 sat pos");
    drive(3, -32768, -32768, 1, 0, 1, 0, "R11 zero pos");
    drive(3, -32768, -32768, 1, 1, 2, 0, "R12 wrap pos");
    drive(3, -32768, 32767, 1, 1, 0, 0, "R9 no ovf");
    drive(1, -32768, 32767, 1, 1, 0, 0, "R9 sat neg");
    drive(1, 0, 0, 0, 1, 0, 1, "R10 sym neg");
    drive(1, 0, 0, 0, 1, 3, 0, "R12 wrap neg");
    drive(1, 0, 0, 0, 2, 1, 0, "R11 zero neg");

    drive(3, -32768, -32768, 1, 1, 0, 1, "R10 setup");
    drive(2, -32768, -32768, 1, 1, 0, 1, "R10 zero acc");
    drive(2, -32768, -32768, 1, 1, 0, 1, "R10 exact min");
    drive(1, 0, 0, 0, 1, 0, 0, "R9 exact min");

    drive(0, 0, 0, 0, 1, 2, 0, "R4 clear");
    for (int i = 0; i < 300; i++)
      drive(1, -32768, -32768, 1, 1, 2, 0, "R4 guard/wrap");

    // Back-pressure
    out_ready = 1'b0;
    drive(3, 1000, 7, 0, 1, 0, 0, "R5 stalled result");
    in_valid = 1'b1; in_op = 2'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R5 in_ready low", in_ready, 0);
      chk(out_valid == 1'b1, "R5 out_valid held", out_valid, 1);
      chk(longint'($signed(acc_out)) == 7000, "R5 acc held", longint'($signed(acc_out)), 7000);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 drained", out_valid, 0);
    @(posedge clk); #1;

    for (int i = 0; i < 300; i++) begin
      int a, b;
      a = int'($urandom_range(0, 65535)) - 32768;
      b = int'($urandom_range(0, 65535)) - 32768;
      drive(int'($urandom_range(0, 3)), a, b, 1'($urandom_range(0, 1)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), "R4 mixed");
    end

    repeat (4) @(posedge clk);
    chk(sb.size() == 0, "R5 pending results", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule